// File: doc/BRIEF.md
# Vertical Six-Tap Half-Sample Luma Interpolator

This block produces the vertical half-sample positions of a luma prediction block. Reference rows of unsigned 8-bit pixels arrive one whole row per transfer on a valid/ready stream. A short history of recent rows is kept for every column. Once enough history has been gathered, each new row completes a six-sample column window, and all columns of an output row are filtered together. Each output is rounded, shifted and clamped back to 8 bits.

A block is 4, 8 or 16 pixels wide and 4, 8 or 16 rows tall. The upstream source sends the block's rows from two rows above the first output row down to three rows below the last one, so a block of height H takes H+5 input rows. Output rows leave on a second valid/ready stream. Start and end markers frame each block, and a one-cycle pulse follows the final handshake. The shape is taken from the configuration inputs at the first row of each block.

Top module: `vfir_top`

## Requirements
- R1: Each output pixel equals clamp(((a+f) + 20*(c+d) - 5*(b+e) + 16) >>> 5, 0, 255). Here a..f are six vertically consecutive input pixels of the same column, and a is the oldest.
- R2: In a block of height H, input rows 0 to 4 only fill the history. Accepted input row k (k>=5) yields output row k-5, so the block yields exactly H output rows from H+5 input rows.
- R3: Results below zero give 0 and results above 255 give 255. This holds for negative intermediate sums, which are kept signed.
- R4: Width code cfg_width 0, 1, 2 or 3 selects 4, 8, 16 or 16 columns. Column i occupies bits [8i+7:8i] of in_row and out_row, with column 0 at the least significant end. Output columns at or beyond the width are 0.
- R5: Height code cfg_height 0, 1, 2 or 3 selects 4, 8, 16 or 16 rows. At a width of 4, height codes 2 and 3 give 8 rows.
- R6: out_sof is high with the first output row of a block. out_eof is high with the last output row.
- R7: While out_valid is high and out_ready is low, out_valid stays high, out_row does not change and in_ready is low. No row is lost or repeated.
- R8: done is high for exactly one cycle, the cycle after the handshake of the row marked out_eof.
- R9: The configuration inputs are sampled only with the first input row of a block. Changes during the block have no effect.
- R10: After reset, out_valid and done are low and in_ready is high. Reset discards a partly received block.
- R11: out_valid is high in the cycle after the handshake of an input row with index 5 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Block width code |
| cfg_height | input | 2 | Block height code |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Input row can be taken |
| in_row | input | 128 | One reference row, 16 pixels |
| out_valid | output | 1 | Output row held |
| out_ready | input | 1 | Downstream takes the output row |
| out_row | output | 128 | One filtered row, 16 pixels |
| out_sof | output | 1 | First output row of the block |
| out_eof | output | 1 | Last output row of the block |
| done | output | 1 | Block finished pulse |

## Verification
Each result is registered once. A filtered row appears on out_row in the cycle after the handshake of the input row that completes its window. done appears in the cycle after the handshake of the final output row, and drops one cycle later. The bench drives inputs on the falling edge and samples one nanosecond later, before the rising edge. It counts input acceptance by reading in_ready in that same window. Each latency check is placed at the first falling-edge sample after the rising edge concerned, so every register stage is counted.

// File: rtl/vfir_pkg.sv
package vfir_pkg;
  localparam int PIX_W  = 8;
  localparam int ACC_W  = 16;
  localparam int HIST   = 5;
  localparam int K_MID  = 20;
  localparam int K_NEAR = 5;
  localparam int RND    = 16;
  localparam int SHIFT  = 5;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  // Signed six-tap column sum; a is the oldest sample.
  function automatic logic signed [ACC_W-1:0] tap_sum(
    input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b,
    input logic [PIX_W-1:0] c, input logic [PIX_W-1:0] d,
    input logic [PIX_W-1:0] e, input logic [PIX_W-1:0] f);
    int t;
    t = int'(a) + int'(f) + K_MID * (int'(c) + int'(d)) - K_NEAR * (int'(b) + int'(e));
    return t[ACC_W-1:0];
  endfunction

  // Round, arithmetic shift and clamp to the pixel range.
  function automatic logic [PIX_W-1:0] round_clip(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] r;
    r = (s + ACC_W'(RND)) >>> SHIFT;
    if (r < 0)
      return '0;
    else if (r > ACC_W'(PIX_MAX))
      return PIX_W'(PIX_MAX);
    else
      return r[PIX_W-1:0];
  endfunction

  function automatic int cols_of(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 4;
      2'd1:    return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int rows_of(input logic [1:0] hcode, input logic [1:0] wcode);
    case (hcode)
      2'd0:    return 4;
      2'd1:    return 8;
      default: return (wcode == 2'd0) ? 8 : 16;
    endcase
  endfunction
endpackage

// File: rtl/vfir_linebuf.sv
module vfir_linebuf #(
  parameter int COLS = 16,
  parameter int DEPTH = vfir_pkg::HIST,
  parameter int PW = vfir_pkg::PIX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic [COLS*PW-1:0]         row_in,
  output logic [DEPTH*COLS*PW-1:0]   win_flat
);
  localparam int ROW_W = COLS * PW;

  logic [ROW_W-1:0] stage [DEPTH];

  // stage[0] is the oldest row, stage[DEPTH-1] the newest.
  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    if (j == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stage[j] <= '0;
        else if (shift_en) stage[j] <= row_in;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stage[j] <= '0;
        else if (shift_en) stage[j] <= stage[j+1];
      end
    end
    assign win_flat[j*ROW_W +: ROW_W] = stage[j];
  end
endmodule

// File: rtl/vfir_col_filter.sv
module vfir_col_filter
  import vfir_pkg::*;
(
  input  logic             col_en,
  input  logic [PIX_W-1:0] ta,
  input  logic [PIX_W-1:0] tb,
  input  logic [PIX_W-1:0] tc,
  input  logic [PIX_W-1:0] td,
  input  logic [PIX_W-1:0] te,
  input  logic [PIX_W-1:0] tf,
  output logic [PIX_W-1:0] pix
);
  logic signed [ACC_W-1:0] acc;
  logic [PIX_W-1:0]        clipped;

  assign acc     = tap_sum(ta, tb, tc, td, te, tf);
  assign clipped = round_clip(acc);
  assign pix     = col_en ? clipped : '0;

  // R3: saturation at both ends of the range
  always_comb begin
    if (acc < 0)
      p_neg_floor_r3: assert (clipped == '0);
    if (acc > ACC_W'(PIX_MAX * 32 + 15))
      p_pos_ceil_r3: assert (clipped == PIX_W'(PIX_MAX));
  end
endmodule

// File: rtl/vfir_ctrl.sv
module vfir_ctrl
  import vfir_pkg::*;
#(
  parameter int MAX_COLS = 16,
  parameter int MAX_ROWS = 16,
  localparam int CNT_W = $clog2(MAX_ROWS + HIST + 1),
  localparam int CW = $clog2(MAX_COLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_fire,
  input  logic [1:0]    cfg_width,
  input  logic [1:0]    cfg_height,
  output logic          emit,
  output logic          first_out,
  output logic          last_in,
  output logic [CW-1:0] act_cols
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] total_q;
  logic             block_start;

  assign block_start = in_fire && (cnt_q == '0);
  assign emit        = cnt_q >= CNT_W'(HIST);
  assign first_out   = cnt_q == CNT_W'(HIST);
  assign last_in     = (cnt_q != '0) && (cnt_q == total_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      total_q  <= CNT_W'(4 + HIST);
      act_cols <= CW'(4);
    end else begin
      if (block_start) begin
        total_q  <= CNT_W'(rows_of(cfg_height, cfg_width) + HIST);
        act_cols <= CW'(cols_of(cfg_width));
      end
      if (in_fire)
        cnt_q <= last_in ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: the row counter never passes the block's input length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < total_q));
  // R2: the block returns to idle after its last input row
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && last_in) |=> (cnt_q == '0));
endmodule

// File: rtl/vfir_top.sv
module vfir_top
  import vfir_pkg::*;
#(
  parameter int MAX_COLS = 16,
  parameter int MAX_ROWS = 16,
  localparam int ROW_W = MAX_COLS * PIX_W,
  localparam int CW = $clog2(MAX_COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_width,
  input  logic [1:0]       cfg_height,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ROW_W-1:0] in_row,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ROW_W-1:0] out_row,
  output logic             out_sof,
  output logic             out_eof,
  output logic             done
);
  logic                         in_fire;
  logic                         out_fire;
  logic                         emit, first_out, last_in;
  logic [CW-1:0]                act_cols;
  logic [HIST*ROW_W-1:0]        win_flat;
  logic [ROW_W-1:0]             filt_row;
  logic [MAX_COLS-1:0]          col_en;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  vfir_ctrl #(.MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .emit(emit), .first_out(first_out), .last_in(last_in), .act_cols(act_cols)
  );

  vfir_linebuf #(.COLS(MAX_COLS), .DEPTH(HIST), .PW(PIX_W)) u_lbuf (
    .clk(clk), .rst_n(rst_n), .shift_en(in_fire), .row_in(in_row), .win_flat(win_flat)
  );

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    assign col_en[c] = CW'(c) < act_cols;
    vfir_col_filter u_flt (
      .col_en(col_en[c]),
      .ta(win_flat[(0*MAX_COLS + c)*PIX_W +: PIX_W]),
      .tb(win_flat[(1*MAX_COLS + c)*PIX_W +: PIX_W]),
      .tc(win_flat[(2*MAX_COLS + c)*PIX_W +: PIX_W]),
      .td(win_flat[(3*MAX_COLS + c)*PIX_W +: PIX_W]),
      .te(win_flat[(4*MAX_COLS + c)*PIX_W +: PIX_W]),
      .tf(in_row[c*PIX_W +: PIX_W]),
      .pix(filt_row[c*PIX_W +: PIX_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= out_fire && out_eof;
      if (in_fire && emit) begin
        out_valid <= 1'b1;
        out_row   <= filt_row;
        out_sof   <= first_out;
        out_eof   <= last_in;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: a stalled row is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_eof)));
  // R7: no input is taken while the output is stalled
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R8: completion pulse follows the end-of-block handshake
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_eof) |=> done);
  p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: a block has at least four rows, so the markers never coincide
  p_markers_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sof && out_eof));
  // R4: narrow blocks leave the upper columns at zero
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && act_cols == CW'(4)) |-> (out_row[ROW_W-1:4*PIX_W] == '0));
  // R11: one register between a completing input row and its output
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && emit) |=> out_valid);
endmodule

// File: tb/vfir_top_bench.sv
`timescale 1ns/1ps
module vfir_top_bench;
  localparam int COLS = 16;
  localparam int RW = COLS * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_width = '0, cfg_height = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [RW-1:0] in_row = '0;
  logic in_ready, out_valid, out_sof, out_eof, done;
  logic [RW-1:0] out_row;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vfir_top u_vfir_top (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_sof(out_sof), .out_eof(out_eof), .done(done)
  );

  // {a,b,c,d,e,f,expected} per column of the first output row
  localparam logic [55:0] VEC [16] = '{
    {8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
    {8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100},
    {8'd0,   8'd0,   8'd255, 8'd255, 8'd0,   8'd0,   8'd255},
    {8'd0,   8'd255, 8'd0,   8'd0,   8'd255, 8'd0,   8'd0},
    {8'd255, 8'd0,   8'd0,   8'd0,   8'd0,   8'd255, 8'd16},
    {8'd0,   8'd0,   8'd255, 8'd0,   8'd0,   8'd0,   8'd159},
    {8'd0,   8'd255, 8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
    {8'd32,  8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd1},
    {8'd15,  8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0},
    {8'd16,  8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd1},
    {8'd0,   8'd0,   8'd10,  8'd10,  8'd0,   8'd0,   8'd13},
    {8'd1,   8'd2,   8'd3,   8'd4,   8'd5,   8'd6,   8'd4},
    {8'd0,   8'd50,  8'd60,  8'd60,  8'd50,  8'd0,   8'd59},
    {8'd10,  8'd20,  8'd30,  8'd40,  8'd50,  8'd60,  8'd35},
    {8'd200, 8'd0,   8'd20,  8'd20,  8'd0,   8'd200, 8'd38}
  };

  logic [RW-1:0] blk_rows [0:20];
  bit table_mode = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_pix(input int r, input int c, input int w);
    int v [6];
    int s;
    if (c >= w) return 8'd0;
    for (int j = 0; j < 6; j++) v[j] = int'(blk_rows[r+j][c*8 +: 8]);
    s = 20 * (v[2] + v[3]) + (v[0] + v[5]) - 5 * (v[1] + v[4]) + 16;
    if (s < 0) return 8'd0;
    s = s / 32;
    return (s > 255) ? 8'd255 : 8'(s);
  endfunction

  function automatic logic [RW-1:0] model_row(input int r, input int w);
    logic [RW-1:0] x;
    for (int c = 0; c < COLS; c++) x[c*8 +: 8] = model_pix(r, c, w);
    return x;
  endfunction

  task automatic fill_rows(input int seed);
    for (int k = 0; k < 21; k++)
      for (int c = 0; c < COLS; c++)
        blk_rows[k][c*8 +: 8] = (((k + c + seed) % 5) == 0) ? 8'd255 :
                                8'((k * 73 + c * 41 + seed * 19) % 256);
  endtask

  task automatic drive(input int wc, input int hc, input int nrows, input bit chg);
    for (int k = 0; k < nrows; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_row = blk_rows[k];
      if (k == 0) begin cfg_width = 2'(wc); cfg_height = 2'(hc); end
      else if (chg) begin cfg_width = 2'd2; cfg_height = 2'd0; end  // R9 mid-block change
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      if (k >= 5) chk(out_valid == 1'b1, "R11 out_valid after row", RW'(out_valid), RW'(1));
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic monitor(input int exp_h, input int exp_w, input int bp);
    int got = 0;
    int cyc = 0;
    bit stall_prev = 1'b0;
    logic [RW-1:0] held = '0;
    logic [RW-1:0] exp;
    while (got < exp_h) begin
      @(negedge clk);
      cyc++;
      out_ready = (bp == 0) ? 1'b1 : ((cyc % 3) != 0);
      #1;
      if (stall_prev) begin
        chk(out_valid && out_row == held, "R7 held row", out_row, held);
      end
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R7 in_ready during stall", RW'(in_ready), RW'(0));
      stall_prev = out_valid && !out_ready;
      held = out_row;
      if (out_valid && out_ready) begin
        exp = model_row(got, exp_w);
        chk(out_row == exp, "R1 R4 R3 row value", out_row, exp);
        if (table_mode && got == 0)
          for (int c = 0; c < COLS; c++)
            chk(out_row[c*8 +: 8] == VEC[c][7:0], "R1 R3 table column",
                RW'(out_row[c*8 +: 8]), RW'(VEC[c][7:0]));
        chk(out_sof == (got == 0), "R6 sof", RW'(out_sof), RW'(got == 0));
        chk(out_eof == (got == exp_h - 1), "R6 eof", RW'(out_eof), RW'(got == exp_h - 1));
        got++;
        if (got == exp_h) begin
          @(posedge clk); #1;
          chk(done == 1'b1, "R8 done high", RW'(done), RW'(1));
          @(posedge clk); #1;
          chk(done == 1'b0, "R8 done single cycle", RW'(done), RW'(0));
        end
      end
    end
    out_ready = 1'b1;
  endtask

  task automatic run_block(input int wc, input int hc, input int h, input int w,
                           input bit chg, input int bp);
    fork
      drive(wc, hc, h + 5, chg);
      monitor(h, w, bp);
    join
    repeat (5) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R2 no extra rows", RW'(out_valid), RW'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid in reset", RW'(out_valid), RW'(0));
    chk(done == 1'b0, "R10 done in reset", RW'(done), RW'(0));
    chk(in_ready == 1'b1, "R10 in_ready in reset", RW'(in_ready), RW'(1));
    @(negedge clk);
    rst_n = 1'b1;

    // table vectors: width 16, height 4
    for (int k = 0; k < 21; k++)
      for (int c = 0; c < COLS; c++)
        blk_rows[k][c*8 +: 8] = (k < 6) ? VEC[c][55 - 8*k -: 8] : 8'((k * 37 + c * 11) % 256);
    table_mode = 1'b1;
    run_block(2, 0, 4, 16, 1'b0, 0);
    table_mode = 1'b0;

    // R5 width 4 with height code 2 gives 8 rows; R9 config changed mid-block
    fill_rows(3);
    run_block(0, 2, 8, 4, 1'b1, 0);

    // R7 back-pressure, width 8, height 16
    fill_rows(7);
    run_block(1, 3, 16, 8, 1'b0, 1);

    // width code 3, height 8, back-pressure
    fill_rows(11);
    run_block(3, 1, 8, 16, 1'b0, 1);

    // R10 reset mid-block discards partial rows
    fill_rows(2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); in_valid = 1'b1; in_row = blk_rows[k]; cfg_width = 2'd2; cfg_height = 2'd1;
    end
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10 reset mid-block", RW'(out_valid), RW'(0));
    @(negedge clk); rst_n = 1'b1;
    fill_rows(5);
    run_block(0, 0, 4, 4, 1'b0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule